// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It picks one start-of-conversion source from a small set: a software start strobe, one of three timer overflow pulses, or a rising edge on an external start pin. Once a conversion is accepted, it sequences an optional extra tracking interval, then the hold and approximation phases, and finally loads the result register and raises a completion pulse. All phase timing advances on a SAR clock enable that is derived from the system clock outside the block.

During approximation the block presents a trial code to an external DAC and reads back a single comparator bit. One bit is settled per SAR clock, starting from the MSB. A short mode resolves only the upper bits and finishes two SAR clocks sooner. The track output drives the sample switch. When an internal source is chosen, the switch tracks whenever the block is idle. When the pin is the source, tracking while idle follows either the delay option or the pin level.

Top module: `sar_seq`

## Requirements
- R1: The 3-bit `conv_mode` code selects the start source. 000 selects `sw_go`, and 001, 010 and 011 select `tmr_ovf[0]`, `tmr_ovf[1]` and `tmr_ovf[2]`. Any code 1xx selects a rising edge of `ext_start`. Pulses on sources that are not selected start nothing.
- R2: With `dly_en`=0 and `short_en`=0, `done` follows the 14th SAR clock enable counted after the trigger.
- R3: With `dly_en`=1 and `short_en`=0, `done` follows the 17th SAR clock enable. During the first 3 of these enables the block keeps tracking.
- R4: With `short_en`=1, `done` follows the 12th SAR clock enable without delay, or the 15th with delay.
- R5: `track` is 1 during the delay interval and 0 for the whole of the conversion interval.
- R6: While idle, `track` is 1 for codes 0xx. For codes 1xx it is 1 when `dly_en`=1 and equals the inverse of the pin level when `dly_en`=0.
- R7: The result is the largest code not above the analog input, where a bit is kept when `cmp_hi`=1 (input at or above the trial code). In short mode only the upper RES_W-2 bits are resolved, and bits [1:0] of the result are 0.
- R8: `busy` is 1 from the cycle after the trigger until `done`. `done` lasts one clock cycle, and `result` changes only in the cycle `done` rises.
- R9: Triggers that arrive while `busy`=1 are ignored. `dly_en` and `short_en` are taken at the trigger, so changing them during a conversion has no effect on it.
- R10: Synchronous `rst` returns the block to idle with `busy`=0, `done`=0, `result`=0, `dac_code`=0 and, for mode 000, `track`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sar_ce | input | 1 | SAR clock enable, one cycle per SAR clock |
| conv_mode | input | 3 | Start source select |
| dly_en | input | 1 | Add three tracking SAR clocks before converting |
| short_en | input | 1 | Resolve only the upper bits |
| sw_go | input | 1 | Software start strobe |
| tmr_ovf | input | 3 | Timer overflow pulses |
| ext_start | input | 1 | External start pin (asynchronous) |
| cmp_hi | input | 1 | Comparator: input at or above the trial code |
| track | output | 1 | Sample switch: 1 = track, 0 = hold |
| dac_code | output | RES_W | Trial code to the DAC |
| result | output | RES_W | Last conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit result, two bits dropped in short mode, a three-clock delay interval and the pin passed through a two-flop synchronizer. With these values all four SAR clock totals (14, 17, 12 and 15) and both result widths can be reached. The synchronizer adds latency to pin triggers, so the bench counts SAR clocks only while `busy` is high. The comparator model lets the bench check the approximation against the input value rather than against the trial sequence.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DELAY = 2'd1,
      PH_CONV  = 2'd2
   } phase_t;

   localparam int PRE_CLKS  = 2;  // hold settling before the first bit
   localparam int POST_CLKS = 2;  // wrap-up after the last bit
endpackage

// File: rtl/sar_seq_trig.sv
module sar_seq_trig #(
   parameter int N_TMR    = 3,
   parameter bit PIN_SYNC = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       mode,
   input  logic             sw_go,
   input  logic [N_TMR-1:0] tmr_ovf,
   input  logic             ext_pin,
   output logic             trig,
   output logic             pin_lvl
);
   logic             pin_q;
   logic [N_TMR-1:0] tmr_hit;

   if (N_TMR < 1 || N_TMR > 3) begin : g_bad_tmr
      $error("N_TMR must be 1..3");
   end

   if (PIN_SYNC) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk) begin
         if (rst) sync_q <= 2'b00;
         else     sync_q <= {sync_q[0], ext_pin};
      end
      assign pin_lvl = sync_q[1];
   end else begin : g_direct
      assign pin_lvl = ext_pin;
   end

   always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b1;
      else     pin_q <= pin_lvl;
   end

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      assign tmr_hit[i] = (mode[1:0] == 2'(i + 1)) && tmr_ovf[i];
   end

   always_comb begin
      if (mode[2])               trig = pin_lvl && !pin_q;
      else if (mode[1:0] == 2'd0) trig = sw_go;
      else                       trig = |tmr_hit;
   end

   // R1: a pin-selected trigger only on a rising level
   p_pin_edge_r1: assert property (@(posedge clk) disable iff (rst)
      (mode[2] && trig) |-> (pin_lvl && !pin_q));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int RES_W      = 10,
   parameter int SHORT_DROP = 2,
   parameter int DLY_CLKS   = 3
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   trig,
   input  logic   sar_ce,
   input  logic   dly_in,
   input  logic   short_in,
   output phase_t phase,
   output logic   short_q,
   output logic   load,
   output logic   bit_step,
   output logic   last_bit,
   output logic   finish,
   output logic   done
);
   localparam int TOT_FULL  = RES_W + PRE_CLKS + POST_CLKS;
   localparam int TOT_SHORT = TOT_FULL - SHORT_DROP;
   localparam int CNT_MAX   = (TOT_FULL > DLY_CLKS) ? TOT_FULL : DLY_CLKS;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] total;
   logic [CNT_W-1:0] bit_end;
   logic             in_conv;

   assign total   = short_q ? CNT_W'(TOT_SHORT) : CNT_W'(TOT_FULL);
   assign bit_end = short_q ? CNT_W'(PRE_CLKS + RES_W - SHORT_DROP)
                            : CNT_W'(PRE_CLKS + RES_W);
   assign in_conv  = (phase == PH_CONV);
   assign load     = sar_ce && in_conv && (cnt == CNT_W'(PRE_CLKS - 1));
   assign bit_step = sar_ce && in_conv && (cnt >= CNT_W'(PRE_CLKS)) && (cnt < bit_end);
   assign last_bit = (cnt == bit_end - 1'b1);
   assign finish   = sar_ce && in_conv && (cnt == total - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         short_q <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: if (trig) begin
               short_q <= short_in;
               cnt     <= '0;
               phase   <= (dly_in && DLY_CLKS > 0) ? PH_DELAY : PH_CONV;
            end
            PH_DELAY: if (sar_ce) begin
               if (cnt == CNT_W'(DLY_CLKS - 1)) begin
                  cnt   <= '0;
                  phase <= PH_CONV;
               end else cnt <= cnt + 1'b1;
            end
            PH_CONV: if (sar_ce) begin
               if (finish) begin
                  cnt   <= '0;
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8: completion is one cycle wide
   p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R8: completion only ends a conversion interval
   p_done_from_conv_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(phase) == PH_CONV && phase == PH_IDLE));
   // R1: an accepted trigger leaves idle
   p_start_r1: assert property (@(posedge clk) disable iff (rst)
      (trig && phase == PH_IDLE) |=> (phase != PH_IDLE));
   // R9: the latched width does not move while converting
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (phase != PH_IDLE) |=> $stable(short_q));
   // R3: the delay interval never exceeds its length
   p_delay_len_r3: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_DELAY) |-> (cnt < CNT_W'(DLY_CLKS)));
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             load,
   input  logic             bit_step,
   input  logic             last_bit,
   input  logic             finish,
   input  logic             cmp_hi,
   output logic [RES_W-1:0] code,
   output logic [RES_W-1:0] result
);
   logic [RES_W-1:0] mask;
   logic [RES_W-1:0] kept;

   assign kept = cmp_hi ? code : (code & ~mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         code   <= '0;
         mask   <= '0;
         result <= '0;
      end else begin
         if (start) begin
            code <= '0;
            mask <= '0;
         end else if (load) begin
            code <= {1'b1, {(RES_W-1){1'b0}}};
            mask <= {1'b1, {(RES_W-1){1'b0}}};
         end else if (bit_step) begin
            code <= last_bit ? kept : (kept | (mask >> 1));
            mask <= last_bit ? '0 : (mask >> 1);
         end
         if (finish) result <= code;
      end
   end

   // R7: at most one bit under test
   p_mask_onehot_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mask));
   // R8: result only moves on completion
   p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !finish |=> $stable(result));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_seq_pkg::*;
#(
   parameter int RES_W      = 10,
   parameter int SHORT_DROP = 2,
   parameter int DLY_CLKS   = 3,
   parameter bit PIN_SYNC   = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sar_ce,
   input  logic [2:0]       conv_mode,
   input  logic             dly_en,
   input  logic             short_en,
   input  logic             sw_go,
   input  logic [2:0]       tmr_ovf,
   input  logic             ext_start,
   input  logic             cmp_hi,
   output logic             track,
   output logic [RES_W-1:0] dac_code,
   output logic [RES_W-1:0] result,
   output logic             busy,
   output logic             done
);
   if (RES_W < 4 || SHORT_DROP < 1 || SHORT_DROP > RES_W - 2) begin : g_bad_width
      $error("RES_W/SHORT_DROP out of range");
   end
   if (DLY_CLKS < 0 || DLY_CLKS > 15) begin : g_bad_dly
      $error("DLY_CLKS out of range");
   end

   phase_t phase;
   logic   trig, pin_lvl, short_q, load, bit_step, last_bit, finish, accept;

   assign busy   = (phase != PH_IDLE);
   assign accept = trig && !busy;

   sar_seq_trig #(.N_TMR(3), .PIN_SYNC(PIN_SYNC)) u_trig (
      .clk(clk), .rst(rst), .mode(conv_mode), .sw_go(sw_go), .tmr_ovf(tmr_ovf),
      .ext_pin(ext_start), .trig(trig), .pin_lvl(pin_lvl)
   );

   sar_seq_ctrl #(.RES_W(RES_W), .SHORT_DROP(SHORT_DROP), .DLY_CLKS(DLY_CLKS)) u_ctrl (
      .clk(clk), .rst(rst), .trig(trig), .sar_ce(sar_ce), .dly_in(dly_en),
      .short_in(short_en), .phase(phase), .short_q(short_q), .load(load),
      .bit_step(bit_step), .last_bit(last_bit), .finish(finish), .done(done)
   );

   sar_seq_core #(.RES_W(RES_W)) u_core (
      .clk(clk), .rst(rst), .start(accept), .load(load), .bit_step(bit_step),
      .last_bit(last_bit), .finish(finish), .cmp_hi(cmp_hi),
      .code(dac_code), .result(result)
   );

   always_comb begin
      case (phase)
         PH_DELAY: track = 1'b1;
         PH_CONV:  track = 1'b0;
         default:  track = conv_mode[2] ? (dly_en || !pin_lvl) : 1'b1;
      endcase
   end

   // R7: short results leave the dropped bits clear
   p_short_lsbs_r7: assert property (@(posedge clk) disable iff (rst)
      (done && short_q) |-> (result[SHORT_DROP-1:0] == '0));
   // R5: the trial code is never presented while tracking in a conversion
   p_hold_busy_r5: assert property (@(posedge clk) disable iff (rst)
      (busy && dac_code != '0) |-> !track);
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sar_ce = 1'b0;
   logic [2:0] conv_mode = 3'd0;
   logic       dly_en = 1'b0, short_en = 1'b0, sw_go = 1'b0, ext_start = 1'b0;
   logic [2:0] tmr_ovf = 3'd0;
   logic [9:0] vin = 10'd0;
   logic       cmp_hi, track, busy, done;
   logic [9:0] dac_code, result;
   logic [1:0] div = 2'd0;
   int         checks = 0, fails = 0, ce_cnt = 0, cyc = 0;

   always #4 clk = ~clk;  // 125 MHz

   sar_seq uut (
      .clk(clk), .rst(rst), .sar_ce(sar_ce), .conv_mode(conv_mode), .dly_en(dly_en),
      .short_en(short_en), .sw_go(sw_go), .tmr_ovf(tmr_ovf), .ext_start(ext_start),
      .cmp_hi(cmp_hi), .track(track), .dac_code(dac_code), .result(result),
      .busy(busy), .done(done)
   );

   assign cmp_hi = (vin >= dac_code);  // comparator model

   always @(posedge clk) begin
      div    <= div + 2'd1;
      sar_ce <= (div == 2'd3);
      cyc    <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act=%0d exp<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   always @(negedge clk) if (busy && sar_ce) ce_cnt <= ce_cnt + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic cyc_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // pulse or raise the source selected by m
   task automatic fire(input logic [2:0] m);
      @(negedge clk);
      ce_cnt = 0;
      if (m[2]) ext_start = 1'b1;
      else if (m == 3'd0) sw_go = 1'b1;
      else tmr_ovf = 3'b001 << (m - 3'd1);
      @(negedge clk);
      sw_go = 1'b0;
      tmr_ovf = 3'd0;
   endtask

   task automatic wait_done(output int clks);
      clks = -1;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (done) begin
            clks = ce_cnt;
            break;
         end
      end
   endtask

   // {mode, dly, short, vin, expected result, expected SAR clocks}
   localparam int NV = 8;
   localparam logic [29:0] VEC [NV] = '{
      {3'b000, 1'b0, 1'b0, 10'd512,  10'd512,  5'd14},
      {3'b001, 1'b0, 1'b0, 10'd0,    10'd0,    5'd14},
      {3'b010, 1'b1, 1'b0, 10'd1023, 10'd1023, 5'd17},
      {3'b011, 1'b0, 1'b1, 10'd701,  10'd700,  5'd12},
      {3'b100, 1'b1, 1'b1, 10'd1023, 10'd1020, 5'd15},
      {3'b101, 1'b0, 1'b0, 10'd341,  10'd341,  5'd14},
      {3'b000, 1'b1, 1'b1, 10'd3,    10'd0,    5'd15},
      {3'b111, 1'b1, 1'b0, 10'd777,  10'd777,  5'd17}
   };

   initial begin
      int clks;
      logic [9:0] prev;
      cyc_n(3);
      rst = 1'b0;
      cyc_n(1);
      // R10 reset state
      chk(!busy && !done, "R10 busy/done", {busy, done}, 0);
      chk(result == 0 && dac_code == 0, "R10 result/code", result, 0);
      chk(track == 1'b1, "R10 track", track, 1);

      for (int v = 0; v < NV; v++) begin
         conv_mode = VEC[v][29:27];
         dly_en    = VEC[v][26];
         short_en  = VEC[v][25];
         vin       = VEC[v][24:15];
         cyc_n(4);
         prev = result;
         fire(conv_mode);
         cyc_n(4);
         chk(busy, "R1 source accepted", busy, 1);
         chk(result == prev, "R8 result held while busy", result, prev);
         wait_done(clks);
         chk(clks == int'(VEC[v][4:0]), "R2 R3 R4 SAR clocks", clks, VEC[v][4:0]);
         chk(result == VEC[v][14:5], "R7 result", result, VEC[v][14:5]);
         cyc_n(1);
         chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
         ext_start = 1'b0;
         cyc_n(4);
      end

      // R1 unselected sources start nothing
      conv_mode = 3'b001; dly_en = 0; short_en = 0;
      fire(3'b000);
      cyc_n(8);
      chk(!busy, "R1 sw_go ignored in mode 001", busy, 0);
      conv_mode = 3'b000;
      fire(3'b011);
      cyc_n(8);
      chk(!busy, "R1 timer ignored in mode 000", busy, 0);

      // R5 track through delay then conversion
      dly_en = 1; vin = 10'd200;
      fire(3'b000);
      chk(busy && track, "R5 track in delay", track, 1);
      while (ce_cnt < 4) @(negedge clk);
      chk(!track, "R5 hold in conversion", track, 0);
      wait_done(clks);
      chk(clks == 17 && result == 200, "R3 delayed run", clks, 17);

      // R9 triggers and option changes mid-conversion are ignored
      dly_en = 0; short_en = 0; vin = 10'd100;
      fire(3'b000);
      while (ce_cnt < 5) @(negedge clk);
      short_en = 1; dly_en = 1;
      sw_go = 1'b1; cyc_n(1); sw_go = 1'b0;
      wait_done(clks);
      chk(clks == 14, "R9 length unchanged", clks, 14);
      chk(result == 100, "R9 width unchanged", result, 100);
      cyc_n(10);
      chk(!busy, "R9 no queued start", busy, 0);

      // R6 idle track in pin mode
      conv_mode = 3'b100; dly_en = 0; short_en = 0;
      cyc_n(4);
      chk(track, "R6 pin low tracks", track, 1);
      fire(3'b100);
      wait_done(clks);
      cyc_n(2);
      chk(!track, "R6 pin high holds", track, 0);
      dly_en = 1;
      cyc_n(1);
      chk(track, "R6 delay bit tracks", track, 1);
      dly_en = 0; ext_start = 0;
      cyc_n(4);
      chk(track, "R6 pin low again", track, 1);

      // R10 reset mid-conversion
      conv_mode = 3'b000;
      fire(3'b000);
      cyc_n(10);
      rst = 1'b1; cyc_n(2); rst = 1'b0; cyc_n(1);
      chk(!busy && result == 0 && dac_code == 0, "R10 reset mid-run", result, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule